// File: doc/BRIEF.md
# Two-Wire Configuration Register Interface

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that gives a bus master read and write access to a byte-wide configuration register array kept outside the block. A transfer opens with a start condition and an address byte: a 7-bit device address followed by a direction bit in bit 0, where 0 means write and 1 means read. A write transfer then carries a one-byte register pointer. Every byte after the pointer is data, stored at the pointer, and the pointer advances after each stored byte. To read, the master sets the pointer with a write transfer that carries no data, issues a repeated start and sends the address byte with the read bit. The slave then returns consecutive registers until the master declines a byte.

Both bus lines are sampled through synchronizers into the system clock. Start and stop are recognised as data-line edges while the clock line is high. The block holds no register contents of its own. It presents a one-cycle write strobe with address and data, and a read address whose byte is returned combinationally on a read-data input. The device address is a parameter whose default is 0x69. The serial logic uses only the system clock and its own reset, so it keeps working while the surrounding device is powered down.

Top module: `cfg_twowire_slave`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 0x69) is acknowledged: the slave pulls the data line low through the ninth clock pulse of that byte.
- R2: An address byte with any other device address is not acknowledged, and the slave neither drives the data line nor writes any register until the next start condition.
- R3: The first byte after a matching address byte with bit 0 = 0 is loaded into the register pointer and acknowledged. A transfer that ends after this byte writes nothing, and the pointer it set is kept for a later read.
- R4: Each data byte of a write is stored during its own acknowledge pulse, while the clock line is high and the slave holds the data line low. The store is a one-cycle strobe carrying the current pointer and the received byte, most significant bit first.
- R5: The pointer increments by one after each stored byte and wraps from 2^ADDR_W-1 to 0.
- R6: After a matching address byte with bit 0 = 1, the slave sends the register at the pointer, most significant bit first, and increments the pointer for each byte sent.
- R7: While the master acknowledges (data line low on the ninth pulse), the slave sends the next register. After a not-acknowledge (data line high), it leaves the data line released.
- R8: The slave changes its data-line drive only while the clock line is low, or in response to a start or stop condition.
- R9: A start condition at any point, including in the middle of a byte, releases the data line and restarts address-byte reception. A stop condition returns the slave to idle.
- R10: After reset the data line is released, no write strobe is active, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Register address for the write strobe |
| wr_data_o | output | 8 | Register data for the write strobe |
| rd_addr_o | output | ADDR_W | Current register pointer, used as the read address |
| rd_data_i | input | 8 | Register contents at rd_addr_o |

## Verification
The bench builds the block with its defaults: DEV_ADDR = 0x69, ADDR_W = 8 and two synchronizer stages. With these values the full 256-entry pointer space is tested, including the wrap from 0xFF to 0x00. The bench runs its bus at a quarter period of six system clocks, which leaves a small margin over the three-to-four-cycle synchronizer and edge-detect delay. This checks that acknowledge and read bits settle within the low phase of the clock line. Random register bursts are interleaved with directed cases: a foreign address, a pointer-only write, and a start condition that cuts a byte short.

// File: rtl/cfg2w_pkg.sv
// Shared types for the two-wire configuration slave.
// Assumes bytes are 8 bits, which the bus protocol fixes.
package cfg2w_pkg;
    localparam int BYTE_W = 8;

    // Bus phase of the protocol controller
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for a start condition
        PH_RX,     // shifting in a byte from the master
        PH_ACK,    // slave acknowledge pulse
        PH_TX,     // shifting out a byte to the master
        PH_MACK    // master acknowledge pulse after a sent byte
    } cfg2w_phase_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        RX_DEV,    // device address + direction bit
        RX_PTR,    // register pointer
        RX_DATA    // write data
    } cfg2w_rx_e;
endpackage

// File: rtl/cfg2w_sync.sv
// Synchronizes the two bus lines into clk and derives the bus events:
// clock-line edges plus start and stop conditions.
// Assumes the bus lines idle high; the synchronizers reset to high.
module cfg2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains and one-cycle-delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Event decode from the synchronized lines
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/cfg2w_ctrl.sv
// Protocol controller: address match, pointer load, write strobes,
// sequential reads and acknowledge handling.
// Assumes the bus events come from cfg2w_sync and that rd_data returns
// the register at rd_addr in the same cycle. ADDR_W must not exceed 8.
module cfg2w_ctrl
    import cfg2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    cfg2w_phase_e      phase;
    cfg2w_rx_e         rx_kind;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] ptr;
    logic              read_dir;

    assign rd_addr = ptr;

    // Bus state machine; start/stop override any phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            rx_kind  <= RX_DEV;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            read_dir <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase   <= PH_RX;
                rx_kind <= RX_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: ;
                    PH_RX: begin
                        if (scl_rise && bit_cnt != LAST_BIT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            unique case (rx_kind)
                                RX_DEV: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        read_dir <= shreg[0];
                                        sda_oe   <= 1'b1;
                                        phase    <= PH_ACK;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RX_PTR: begin
                                    ptr    <= ADDR_W'(shreg);
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK;
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (scl_rise && rx_kind == RX_DATA) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= shreg;
                            ptr     <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rx_kind == RX_DEV && read_dir) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                phase  <= PH_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                rx_kind <= (rx_kind == RX_DEV) ? RX_PTR : RX_DATA;
                                phase   <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_MACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise && sda_s) begin
                            phase <= PH_IDLE;
                        end else if (scl_fall) begin
                            shreg   <= rd_data;
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            phase   <= PH_TX;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R8
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_addr == ADDR_W'(wr_addr + 1'b1));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe && !wr_en));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: rtl/cfg_twowire_slave.sv
// Two-wire configuration register slave: synchronizer/event front end
// feeding the protocol controller. Drives an external register array
// through a write strobe and a combinational read address/data pair.
// Assumes the data pad is open-drain: sda_oe_o = 1 pulls the line low.
module cfg_twowire_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfg2w_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg2w_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en_o),
        .wr_addr   (wr_addr_o),
        .wr_data   (wr_data_o),
        .rd_addr   (rd_addr_o),
        .rd_data   (rd_data_i)
    );
endmodule

// File: tb/test_cfg_twowire_slave.sv
module test_cfg_twowire_slave;
    localparam int Q = 6;
    localparam logic [6:0] DEV = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic sda_line;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0, n_wr = 0, r8_viol = 0, r4_viol = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    cfg_twowire_slave i_cfg_twowire_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    // register array behind the write port, plus R4/R8 monitors
    logic oe_q = 1'b0;
    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            n_wr <= n_wr + 1;
            if (!(scl_m && !sda_line)) r4_viol <= r4_viol + 1;
        end
        if (rst_n && sda_oe != oe_q && scl_m) r8_viol <= r8_viol + 1;
        oe_q <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_burst(input logic [7:0] a, input int len, input logic [7:0] seed_val);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk("R1 write addr ack", ack, 0);
        send_byte(a, ack);           chk("R3 pointer ack", ack, 0);
        for (int k = 0; k < len; k++) begin
            d = seed_val ^ 8'(k * 37);
            send_byte(d, ack);       chk("R4 data ack", ack, 0);
            exp_mem[8'(a + k)] = d;
        end
        bus_stop();
    endtask

    task automatic read_burst(input logic [7:0] a, input int len, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(a, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk("R1 read addr ack", ack, 0);
        for (int k = 0; k < len; k++) begin
            recv_byte((k == len - 1), d);
            chk(req, d, exp_mem[8'(a + k)]);
        end
        tick(Q);
        chk("R7 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int wr_before;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        tick(5); rst_n = 1'b1; tick(2);
        // R10 reset state
        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 wr_en", wr_en, 0);
        chk("R10 pointer", rd_addr, 0);

        // R4 R5 directed burst
        write_burst(8'h10, 4, 8'hA5);
        chk("R5 pointer after burst", rd_addr, 8'h14);
        for (int k = 0; k < 4; k++) chk("R4 stored byte", mem[8'h10 + k], exp_mem[8'h10 + k]);
        // R6 R7 read back
        read_burst(8'h10, 4, "R6 read data");
        chk("R6 pointer after read", rd_addr, 8'h14);

        // R2 foreign address
        wr_before = n_wr;
        bus_start();
        send_byte({7'h2A, 1'b0}, ack); chk("R2 no ack", ack, 1);
        send_byte(8'h00, ack);         chk("R2 still silent", ack, 1);
        send_byte(8'h55, ack);         chk("R2 still silent", ack, 1);
        bus_stop();
        chk("R2 no writes", n_wr - wr_before, 0);

        // R3 pointer-only write, then read without pointer byte
        exp_mem[8'h30] = 8'h3C; mem[8'h30] = 8'h3C;
        wr_before = n_wr;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h30, ack);
        bus_stop();
        chk("R3 no write", n_wr - wr_before, 0);
        chk("R3 pointer kept", rd_addr, 8'h30);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, d);
        bus_stop();
        chk("R3 read at kept pointer", d, 8'h3C);

        // R5 wrap
        write_burst(8'hFE, 3, 8'h5A);
        chk("R5 wrap pointer", rd_addr, 8'h01);
        chk("R5 wrapped byte", mem[8'h00], exp_mem[8'h00]);
        chk("R5 last byte", mem[8'hFF], exp_mem[8'hFF]);

        // R9 start in mid-byte
        bus_start();
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk("R9 restart addr ack", ack, 0);
        send_byte(8'h77, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        exp_mem[8'h77] = 8'hC3;
        chk("R9 write after restart", mem[8'h77], 8'hC3);

        // random bursts
        for (int t = 0; t < 20; t++) begin
            logic [7:0] a;
            int len;
            a   = 8'($urandom);
            len = 1 + int'($urandom_range(3));
            write_burst(a, len, 8'($urandom));
            read_burst(a, len, "R6 R7 random read");
        end

        chk("R8 drive changes with clock line high", r8_viol, 0);
        chk("R4 strobe outside ack pulse", r4_viol, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule